// File: doc/BRIEF.md
# Split-Line Instruction Fetch Aligner

This block sits between a small instruction-line store and the prefetch queue. Given a byte address, it returns the sixteen instruction bytes that begin at that address, in program order, one cycle after the request. The window may cross from the upper half of one 32-byte line into the lower half of the following line. Two read ports with their own tag comparators look up both lines in the same cycle. The two half-lines are joined, and a byte rotator places the byte at the fetch address in output lane 0.

The block flags every byte lane whose source line is resident. It reports whether the whole window hit and, on a miss, which of the two lines was absent. It also checks one stored parity bit per 8-byte group. Lines enter the store only through a whole-line fill port, so the store is read-only from the data side. The store is direct-mapped. Its contents are undefined after reset, apart from the per-line valid bits, which reset clears.

Top module: `split_fetch_aligner`

## Requirements
- R1: A request with `fetch_en` high at a rising edge produces results with `out_valid` high after that same edge. `out_valid` is low after any edge without a request.
- R2: Output lane i (bits 8i+7..8i of `out_bytes`) carries the byte at address `fetch_addr + i`, for i = 0..15, whenever that lane's mask bit is set. This holds across a line boundary. A filled line's byte k sits at bits 8k+7..8k of `fill_data`.
- R3: `out_split` is 1 exactly when address bit 4 is 1 and address bits 3..0 are not all zero. Only in that case does the window draw from two lines.
- R4: A window that is not split uses only its own line. The residency of the next line never affects `out_hit`, `out_mask` or `out_miss_hi`, and `out_miss_hi` stays 0.
- R5: `out_hit` is 1 only when every line the window needs is resident. When `out_hit` is 1, all 16 bits of `out_mask` are 1.
- R6: `out_miss_lo` reports that the line holding the fetch address is absent. `out_miss_hi` reports that the next line is absent during a split. Mask bit i is set exactly when lane i's source line is resident.
- R7: `fill_par[j]` is the even parity (XOR) of line bytes 8j..8j+7. `out_par_err` is 1 when a parity group that supplies at least one output lane comes from a resident line and its XOR disagrees with its stored bit. Groups that supply no lane are ignored.
- R8: After reset, `out_valid` is 0 and every line is absent.
- R9: A fill writes the line's data, tag and parity and marks it resident, replacing whatever line shared its index. A fetch in the same cycle as the fill sees the store's previous contents.
- R10: An address with bits 3..0 equal to zero returns exactly one half-line, with no bytes taken from the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | Write a whole line this cycle |
| fill_line | input | 11 | Line address (byte address bits 15..5) of the fill |
| fill_data | input | 256 | Line bytes, byte k at bits 8k+7..8k |
| fill_par | input | 4 | Parity bit per 8-byte group of the fill |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | 16 | Byte address of the first window byte |
| out_valid | output | 1 | Results below belong to last cycle's request |
| out_split | output | 1 | Window crosses into the next line |
| out_hit | output | 1 | All needed lines were resident |
| out_miss_lo | output | 1 | Line of the fetch address absent |
| out_miss_hi | output | 1 | Next line absent during a split |
| out_par_err | output | 1 | Parity mismatch in a used group |
| out_mask | output | 16 | Per-lane valid flags |
| out_bytes | output | 128 | Sixteen bytes in program order, lane 0 lowest |

## Verification
On every cycle, assertions check that:
- a result follows each request by one edge;
- a hit implies a full mask, and hit is the complement of any miss;
- a window that is not split never reports a next-line miss;
- a fill leaves its line resident with the new tag.

Only the bench scenarios can show that the rotated bytes match the addressed memory at every offset class. The same holds for the following:
- the mixed masks when exactly one line is absent;
- the detection of a deliberately corrupted parity group, while an unused corrupted group stays silent;
- the read-old behaviour of a fill that collides with a fetch.

// File: rtl/fa_pkg.sv
// Package: shared geometry of the split-line fetch aligner.
// Assumes power-of-two line size, set count and parity group size.
package fa_pkg;
    parameter int ADDR_W     = 16;
    parameter int LINE_BYTES = 32;
    parameter int SETS       = 8;
    parameter int PAR_BYTES  = 8;
    parameter int RD_PORTS   = 2;

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int HALF_BYTES = LINE_BYTES / 2;
    localparam int HALF_W     = HALF_BYTES * 8;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int ROT_W      = $clog2(HALF_BYTES);
    localparam int IDX_W      = $clog2(SETS);
    localparam int LA_W       = ADDR_W - OFF_W;
    localparam int TAG_W      = LA_W - IDX_W;
    localparam int PAR_N      = LINE_BYTES / PAR_BYTES;
    localparam int GRP_HALF   = HALF_BYTES / PAR_BYTES;
endpackage

// File: rtl/code_line_store.sv
// Module: code_line_store
// Direct-mapped instruction line store built from flops, with RD_PORTS
// independent read ports, each carrying its own tag comparator.
// Assumes: writes come only from the fill port, one whole line at a time;
// reads are combinational and return pre-fill contents during a fill cycle.
module code_line_store
    import fa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [LA_W-1:0]   fill_line,
    input  logic [LINE_W-1:0] fill_data,
    input  logic [PAR_N-1:0]  fill_par,
    input  logic [LA_W-1:0]   rd_line [RD_PORTS],
    output logic              rd_hit  [RD_PORTS],
    output logic [LINE_W-1:0] rd_data [RD_PORTS],
    output logic [PAR_N-1:0]  rd_par  [RD_PORTS]
);
    logic [LINE_W-1:0] data_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PAR_N-1:0]  par_q  [SETS];
    logic [SETS-1:0]   vld_q;

    logic [IDX_W-1:0] fill_idx;
    assign fill_idx = fill_line[IDX_W-1:0];

    // Residency bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else if (fill_en) vld_q[fill_idx] <= 1'b1;
    end

    // Line payload, tag and parity: written only by a fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[fill_idx] <= fill_data;
            tag_q[fill_idx]  <= fill_line[LA_W-1:IDX_W];
            par_q[fill_idx]  <= fill_par;
        end
    end

    // One lookup path per read port.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic [IDX_W-1:0] idx;
        assign idx        = rd_line[p][IDX_W-1:0];
        assign rd_hit[p]  = vld_q[idx] && (tag_q[idx] == rd_line[p][LA_W-1:IDX_W]);
        assign rd_data[p] = data_q[idx];
        assign rd_par[p]  = par_q[idx];
    end

    // R9: a filled line is resident with its new tag one edge later.
    a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)] &&
                    (tag_q[$past(fill_idx)] == $past(fill_line[LA_W-1:IDX_W])));
endmodule

// File: rtl/half_rotator.sv
// Module: half_rotator
// Joins a first and a second half-line into one double-half span and
// rotates it right by `rot` bytes, so lane i carries span byte i+rot.
// Assumes rot < HALF_BYTES, so the selected index never wraps.
module half_rotator
    import fa_pkg::*;
(
    input  logic [HALF_W-1:0] first_half,
    input  logic [HALF_W-1:0] second_half,
    input  logic [ROT_W-1:0]  rot,
    output logic [HALF_W-1:0] window
);
    logic [2*HALF_W-1:0] span;
    assign span = {second_half, first_half};

    // One byte-wide selector per output lane.
    for (genvar i = 0; i < HALF_BYTES; i++) begin : g_lane
        logic [ROT_W:0] src;
        assign src = (ROT_W+1)'(i) + {1'b0, rot};
        assign window[8*i +: 8] = span[{src, 3'b000} +: 8];
    end
endmodule

// File: rtl/group_parity_check.sv
// Module: group_parity_check
// Recomputes even parity for each 8-byte group of the two selected halves
// and compares it with the stored bits; only enabled groups may flag.
// Assumes groups are PAR_BYTES wide and tile each half exactly.
module group_parity_check
    import fa_pkg::*;
(
    input  logic [2*HALF_W-1:0]   span,
    input  logic [2*GRP_HALF-1:0] span_par,
    input  logic [2*GRP_HALF-1:0] grp_en,
    output logic                  par_err
);
    logic [2*GRP_HALF-1:0] bad;

    // Per-group mismatch, gated by whether the group feeds any lane.
    for (genvar g = 0; g < 2*GRP_HALF; g++) begin : g_grp
        assign bad[g] = grp_en[g] && ((^span[g*PAR_BYTES*8 +: PAR_BYTES*8]) != span_par[g]);
    end

    assign par_err = |bad;
endmodule

// File: rtl/split_fetch_aligner.sv
// Module: split_fetch_aligner (top)
// Fetches a 16-byte instruction window starting at any byte address.
// When the window runs past the end of a line, the upper half of that
// line and the lower half of the next are read through two tag ports in
// one cycle, then rotated into program order. Results are registered.
// Assumes: fills and fetches share one clock; results are one edge late.
module split_fetch_aligner
    import fa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_en,
    input  logic [LA_W-1:0]       fill_line,
    input  logic [LINE_W-1:0]     fill_data,
    input  logic [PAR_N-1:0]      fill_par,
    input  logic                  fetch_en,
    input  logic [ADDR_W-1:0]     fetch_addr,
    output logic                  out_valid,
    output logic                  out_split,
    output logic                  out_hit,
    output logic                  out_miss_lo,
    output logic                  out_miss_hi,
    output logic                  out_par_err,
    output logic [HALF_BYTES-1:0] out_mask,
    output logic [HALF_W-1:0]     out_bytes
);
    logic [LA_W-1:0]   rd_line [RD_PORTS];
    logic              rd_hit  [RD_PORTS];
    logic [LINE_W-1:0] rd_data [RD_PORTS];
    logic [PAR_N-1:0]  rd_par  [RD_PORTS];

    logic [ROT_W-1:0] rot;
    logic             upper_sel;
    logic             split;

    assign rot       = fetch_addr[ROT_W-1:0];
    assign upper_sel = fetch_addr[OFF_W-1];
    assign split     = upper_sel && (rot != '0);

    // Port 0 looks up the addressed line, port 1 the following line.
    assign rd_line[0] = fetch_addr[ADDR_W-1:OFF_W];
    assign rd_line[1] = fetch_addr[ADDR_W-1:OFF_W] + 1'b1;

    code_line_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_line (fill_line),
        .fill_data (fill_data),
        .fill_par  (fill_par),
        .rd_line   (rd_line),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data),
        .rd_par    (rd_par)
    );

    logic [HALF_W-1:0]     first_half, second_half;
    logic [GRP_HALF-1:0]   first_par, second_par;
    logic                  first_hit, second_hit;

    // Half selection: the addressed half, then whichever half follows it.
    always_comb begin
        first_hit = rd_hit[0];
        if (upper_sel) begin
            first_half  = rd_data[0][LINE_W-1 -: HALF_W];
            first_par   = rd_par[0][PAR_N-1 -: GRP_HALF];
            second_half = rd_data[1][HALF_W-1:0];
            second_par  = rd_par[1][GRP_HALF-1:0];
            second_hit  = rd_hit[1];
        end else begin
            first_half  = rd_data[0][HALF_W-1:0];
            first_par   = rd_par[0][GRP_HALF-1:0];
            second_half = rd_data[0][LINE_W-1 -: HALF_W];
            second_par  = rd_par[0][PAR_N-1 -: GRP_HALF];
            second_hit  = rd_hit[0];
        end
    end

    logic [HALF_W-1:0] window;

    half_rotator u_rot (
        .first_half  (first_half),
        .second_half (second_half),
        .rot         (rot),
        .window      (window)
    );

    logic [HALF_BYTES-1:0] mask;

    // Lane validity follows the residency of the lane's source half.
    for (genvar i = 0; i < HALF_BYTES; i++) begin : g_mask
        logic [ROT_W:0] pos;
        assign pos     = (ROT_W+1)'(i) + {1'b0, rot};
        assign mask[i] = pos[ROT_W] ? second_hit : first_hit;
    end

    logic [2*GRP_HALF-1:0] grp_en;

    // A group is checked only if it supplies a lane and its line is resident.
    for (genvar c = 0; c < GRP_HALF; c++) begin : g_gen
        assign grp_en[c]          = first_hit &&
                                    ({1'b0, rot} < (ROT_W+1)'((c+1)*PAR_BYTES));
        assign grp_en[GRP_HALF+c] = second_hit &&
                                    ({1'b0, rot} > (ROT_W+1)'(c*PAR_BYTES));
    end

    logic par_err;

    group_parity_check u_par (
        .span     ({second_half, first_half}),
        .span_par ({second_par, first_par}),
        .grp_en   (grp_en),
        .par_err  (par_err)
    );

    logic miss_lo, miss_hi;
    assign miss_lo = !rd_hit[0];
    assign miss_hi = split && !rd_hit[1];

    // Request flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= fetch_en;
    end

    // Result registers, loaded on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_split   <= 1'b0;
            out_hit     <= 1'b0;
            out_miss_lo <= 1'b0;
            out_miss_hi <= 1'b0;
            out_par_err <= 1'b0;
            out_mask    <= '0;
            out_bytes   <= '0;
        end else if (fetch_en) begin
            out_split   <= split;
            out_hit     <= !miss_lo && !miss_hi;
            out_miss_lo <= miss_lo;
            out_miss_hi <= miss_hi;
            out_par_err <= par_err;
            out_mask    <= mask;
            out_bytes   <= window;
        end
    end

    // R1: one result per request, one edge later.
    a_r1_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> out_valid);
    a_r1_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> !out_valid);
    // R5: a hit means every lane is valid.
    a_r5_hit_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (out_mask == '1));
    // R6: hit and miss flags are mutually consistent.
    a_r6_hit_vs_miss: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit == !(out_miss_lo || out_miss_hi)));
    // R4: a single-line window never blames the next line.
    a_r4_single_no_hi_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_split) |-> !out_miss_hi);
endmodule

// File: tb/split_fetch_aligner_bench.sv
module split_fetch_aligner_bench;
    import fa_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  fill_en = 1'b0;
    logic [LA_W-1:0]       fill_line = '0;
    logic [LINE_W-1:0]     fill_data = '0;
    logic [PAR_N-1:0]      fill_par = '0;
    logic                  fetch_en = 1'b0;
    logic [ADDR_W-1:0]     fetch_addr = '0;
    logic                  out_valid, out_split, out_hit, out_miss_lo, out_miss_hi, out_par_err;
    logic [HALF_BYTES-1:0] out_mask;
    logic [HALF_W-1:0]     out_bytes;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    split_fetch_aligner u_split_fetch_aligner (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_line(fill_line),
        .fill_data(fill_data), .fill_par(fill_par), .fetch_en(fetch_en),
        .fetch_addr(fetch_addr), .out_valid(out_valid), .out_split(out_split),
        .out_hit(out_hit), .out_miss_lo(out_miss_lo), .out_miss_hi(out_miss_hi),
        .out_par_err(out_par_err), .out_mask(out_mask), .out_bytes(out_bytes)
    );

    // Vector: {addr[15:0], split, hit, miss_lo, miss_hi}
    localparam int NV = 14;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {16'h0200, 4'b0100}, {16'h0205, 4'b0100}, {16'h0210, 4'b0100},
        {16'h0213, 4'b1100}, {16'h021F, 4'b1100}, {16'h0238, 4'b1100},
        {16'h0258, 4'b1001}, {16'h0250, 4'b0100}, {16'h0264, 4'b0010},
        {16'h0274, 4'b1011}, {16'h0308, 4'b0010}, {16'h05BC, 4'b1001},
        {16'h05A8, 4'b0100}, {16'h01F4, 4'b1010}
    };

    function automatic logic [7:0] byte_at(int a);
        return 8'((a * 37) + ((a >> 5) * 3) + 90);
    endfunction

    task automatic chk(string req, logic [HALF_W-1:0] act, logic [HALF_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Prepare a fill for line `la`; optionally corrupt parity of group 1.
    task automatic set_fill(int la, bit corrupt);
        for (int k = 0; k < LINE_BYTES; k++) fill_data[8*k +: 8] = byte_at(la * LINE_BYTES + k);
        for (int j = 0; j < PAR_N; j++) fill_par[j] = ^fill_data[64*j +: 64];
        if (corrupt) fill_par[1] = ~fill_par[1];
        fill_line = LA_W'(la);
    endtask

    task automatic do_fill(int la, bit corrupt);
        @(negedge clk);
        set_fill(la, corrupt);
        fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_fetch(int a);
        @(negedge clk);
        fetch_en = 1'b1;
        fetch_addr = ADDR_W'(a);
        @(negedge clk);
        fetch_en = 1'b0;
    endtask

    // Full comparison of one registered result against the requirements.
    task automatic check_window(string tag, int a, bit sp, bit ht, bit mlo, bit mhi, bit pe);
        logic [HALF_BYTES-1:0] emask;
        logic [HALF_W-1:0] ebytes, bmask;
        int rot;
        rot = a & 15;
        ebytes = '0;
        bmask = '0;
        for (int i = 0; i < HALF_BYTES; i++) begin
            bit second;
            second = sp && ((i + rot) >= HALF_BYTES);
            emask[i] = second ? !mhi : !mlo;
            ebytes[8*i +: 8] = byte_at(a + i);
            if (emask[i]) bmask[8*i +: 8] = 8'hFF;
        end
        chk({"R1 valid ", tag}, HALF_W'(out_valid), HALF_W'(1));
        chk({"R3 split ", tag}, HALF_W'(out_split), HALF_W'(sp));
        chk({"R5 hit ", tag}, HALF_W'(out_hit), HALF_W'(ht));
        chk({"R6 miss ", tag}, HALF_W'({out_miss_lo, out_miss_hi}), HALF_W'({mlo, mhi}));
        chk({"R6 mask ", tag}, HALF_W'(out_mask), HALF_W'(emask));
        chk({"R2 bytes ", tag}, out_bytes & bmask, ebytes & bmask);
        chk({"R7 parity ", tag}, HALF_W'(out_par_err), HALF_W'(pe));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 valid after reset", HALF_W'(out_valid), '0);
        rst_n = 1'b1;
        do_fetch(16'h0200);
        check_window("R8 empty", 16'h0200, 0, 0, 1, 0, 0);
        // R1: idle cycle gives no result
        @(negedge clk);
        chk("R1 idle", HALF_W'(out_valid), '0);

        do_fill(16'h10, 0);
        do_fill(16'h11, 0);
        do_fill(16'h12, 0);
        do_fill(16'h2D, 0);

        // Table walk: R2 R3 R4 R5 R6 R10 across offset classes
        for (int v = 0; v < NV; v++) begin
            do_fetch(int'(VEC[v][19:4]));
            check_window("table", int'(VEC[v][19:4]), VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], 0);
        end

        // R7: corrupted group 1 of line 0x2D
        do_fill(16'h2D, 1);
        do_fetch(16'h05A8);
        check_window("R7 used bad group", 16'h05A8, 0, 1, 0, 0, 1);
        do_fetch(16'h05B0);
        check_window("R7 unused bad group R10", 16'h05B0, 0, 1, 0, 0, 0);

        // R9: fill colliding with a fetch reads old contents
        @(negedge clk);
        set_fill(16'h13, 0);
        fill_en = 1'b1;
        fetch_en = 1'b1;
        fetch_addr = 16'h0264;
        @(negedge clk);
        fill_en = 1'b0;
        fetch_en = 1'b0;
        check_window("R9 same cycle", 16'h0264, 0, 0, 1, 0, 0);
        do_fetch(16'h0264);
        check_window("R9 after fill", 16'h0264, 0, 1, 0, 0, 0);
        // R4: split now hits both; then a replacement at index 0
        do_fetch(16'h0258);
        check_window("R9 split now full", 16'h0258, 1, 1, 0, 0, 0);
        do_fill(16'h18, 0);
        do_fetch(16'h0200);
        check_window("R9 replaced", 16'h0200, 0, 0, 1, 0, 0);
        do_fetch(16'h0308);
        check_window("R9 new line", 16'h0308, 0, 1, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule